// File: doc/BRIEF.md
# Breakpoint Patch Unit

This block places software breakpoints by editing a word-addressed instruction memory directly. To arm a breakpoint at a program address, the unit reads the instruction word stored there, keeps it in a small internal table, and overwrites the location with a fixed break opcode. To take the breakpoint out, it puts the kept word back. Two bulk commands walk the whole table. One restores every kept word and leaves the entries in place. The other re-patches every entry, saving whatever word it finds there as the new original.

The unit drives a synchronous one-port memory interface. A read returns its data on the cycle after the request, and a write takes effect on the clock edge. A command is accepted only while the unit is idle. `busy` stays high until a single-cycle `done`, and `err` flags a rejected insert in that same cycle. A separate comparator watches the fetch stream and raises `bp_hit` whenever the fetched word is the break opcode.

Top module: `bp_patch_unit`

## Requirements
- R1: A synchronous reset (`rst` high) returns the unit to idle with `busy`, `done`, `err` and `mem_en` low, and empties the table. It writes nothing to memory, so a following enable-all makes no memory write.
- R2: Insert (`cmd_op` = 0) reads the word at `cmd_addr`, stores it in a free entry and writes 0x9598 to that address. It is busy for 3 cycles: read, write, done.
- R3: If the word read by an insert is 0xFFFF, the insert writes nothing, allocates no entry, and raises `err` with `done` after 3 busy cycles.
- R4: An insert to an address already in the table, or an insert while all DEPTH (8) entries are in use, makes no memory access and raises `err` with `done` after 1 busy cycle.
- R5: Remove (`cmd_op` = 1) of an address in the table writes its saved word back and frees the entry, which can then be reused. It is busy for 2 cycles.
- R6: Remove of an address not in the table changes no memory and ends with `done` after 1 busy cycle, without `err`.
- R7: Disable-all (`cmd_op` = 3) writes every entry's saved word back to its address. It keeps all entries and is busy for DEPTH+1 cycles.
- R8: Enable-all (`cmd_op` = 2) reads the current word at each entry's address. Only where that word differs from 0x9598 does it save the word as the entry's new original and write 0x9598. It is busy for DEPTH + (number of entries) + 1 cycles.
- R9: `done` is high for exactly one cycle, and that cycle is the last cycle of `busy`. A command presented while `busy` is high is ignored.
- R10: `bp_hit` is high in any cycle where `fetch_valid` is high and `fetch_opcode` equals 0x9598, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 2 | 0 insert, 1 remove, 2 enable-all, 3 disable-all |
| cmd_addr | input | AW | Program word address for insert/remove |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejected insert, valid with done |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Read data, valid the cycle after a read |
| fetch_valid | input | 1 | Fetch stream word is valid |
| fetch_opcode | input | DW | Word being fetched |
| bp_hit | output | 1 | Fetched word is the break opcode |

## Verification
Two functions can act in the same cycle: the fetch comparator and the patch write. This happens when the fetch stream points at the very address being patched. The bench keeps its fetch address on an insert target and feeds the comparator straight from its memory model. It then requires `bp_hit` to stay low during the read and write cycles and to rise in the done cycle, when the break word has landed. The second overlap is a command presented while a bulk walk is busy. The bench holds a remove strobe for the whole walk. It judges that the remove was ignored by checking that a later enable-all still re-patches that address.

// File: rtl/bp_patch_pkg.sv
package bp_patch_pkg;

   typedef enum logic [1:0] {
      OP_INSERT  = 2'd0,
      OP_REMOVE  = 2'd1,
      OP_ARM_ALL = 2'd2,
      OP_DISARM  = 2'd3
   } bp_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_WRITE,
      ST_SCAN,
      ST_DONE
   } bp_state_e;

endpackage

// File: rtl/bp_slot_table.sv
module bp_slot_table #(
   parameter int AW    = 8,
   parameter int DW    = 16,
   parameter int DEPTH = 8,
   parameter int IW    = 3
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [AW-1:0] look_addr,
   input  logic [IW-1:0] sel_idx,
   input  logic          alloc_en,
   input  logic [AW-1:0] alloc_addr,
   input  logic [DW-1:0] alloc_word,
   input  logic          resave_en,
   input  logic [DW-1:0] resave_word,
   input  logic          drop_en,
   output logic          hit,
   output logic [IW-1:0] hit_idx,
   output logic          has_free,
   output logic [IW-1:0] free_idx,
   output logic          sel_valid,
   output logic [AW-1:0] sel_addr,
   output logic [DW-1:0] sel_word
);

   logic [DEPTH-1:0] valid_vec;
   logic [DEPTH-1:0] match_vec;
   logic [AW-1:0]    slot_addr [DEPTH];
   logic [DW-1:0]    slot_word [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic          v_q;
      logic [AW-1:0] a_q;
      logic [DW-1:0] w_q;
      logic          here;

      assign here = (sel_idx == IW'(g));

      always_ff @(posedge clk) begin
         if (rst) begin
            v_q <= 1'b0;
         end else if (here) begin
            if (alloc_en) begin
               v_q <= 1'b1;
               a_q <= alloc_addr;
               w_q <= alloc_word;
            end else if (resave_en) begin
               w_q <= resave_word;
            end
            if (drop_en) v_q <= 1'b0;
         end
      end

      assign valid_vec[g] = v_q;
      assign slot_addr[g] = a_q;
      assign slot_word[g] = w_q;
      assign match_vec[g] = v_q && (a_q == look_addr);
   end

   always_comb begin
      hit      = 1'b0;
      hit_idx  = '0;
      has_free = 1'b0;
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (match_vec[i]) begin
            hit     = 1'b1;
            hit_idx = IW'(i);
         end
         if (!valid_vec[i]) begin
            has_free = 1'b1;
            free_idx = IW'(i);
         end
      end
   end

   assign sel_valid = valid_vec[sel_idx];
   assign sel_addr  = slot_addr[sel_idx];
   assign sel_word  = slot_word[sel_idx];

endmodule

// File: rtl/bp_break_detect.sv
module bp_break_detect #(
   parameter int          DW      = 16,
   parameter logic [15:0] BRK     = 16'h9598,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          fetch_valid,
   input  logic [DW-1:0] fetch_opcode,
   output logic          bp_hit
);

   logic raw_hit;
   assign raw_hit = fetch_valid && (fetch_opcode == DW'(BRK));

   if (REG_OUT) begin : g_reg
      logic hit_q;
      always_ff @(posedge clk) begin
         if (rst) hit_q <= 1'b0;
         else     hit_q <= raw_hit;
      end
      assign bp_hit = hit_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst;
      assign bp_hit     = raw_hit;
   end

endmodule

// File: rtl/bp_patch_unit.sv
module bp_patch_unit
   import bp_patch_pkg::*;
#(
   parameter int          AW      = 8,
   parameter int          DW      = 16,
   parameter int          DEPTH   = 8,
   parameter logic [15:0] BRK     = 16'h9598,
   parameter logic [15:0] BLANK   = 16'hFFFF,
   parameter bit          HIT_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cmd_valid,
   input  logic [1:0]    cmd_op,
   input  logic [AW-1:0] cmd_addr,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic          mem_en,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic [DW-1:0] mem_rdata,
   input  logic          fetch_valid,
   input  logic [DW-1:0] fetch_opcode,
   output logic          bp_hit
);

   localparam int          IW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [IW-1:0] LAST   = IW'(DEPTH - 1);
   localparam logic [DW-1:0] BRK_W  = DW'(BRK);
   localparam logic [DW-1:0] BLNK_W = DW'(BLANK);

   if (DEPTH < 2) begin : g_bad_depth
      $error("bp_patch_unit: DEPTH must be at least 2");
   end
   if (DW < 16) begin : g_bad_width
      $error("bp_patch_unit: DW must hold the 16-bit break opcode");
   end
   if (AW < 1) begin : g_bad_addr
      $error("bp_patch_unit: AW must be positive");
   end

   bp_state_e     state_q;
   bp_op_e        op_q;
   logic [IW-1:0] cur_idx;
   logic [AW-1:0] cur_addr;
   logic          err_q;

   logic          tb_hit, tb_has_free, tb_sel_valid;
   logic [IW-1:0] tb_hit_idx, tb_free_idx;
   logic [AW-1:0] tb_sel_addr;
   logic [DW-1:0] tb_sel_word;
   logic          alloc_en, resave_en, drop_en;
   logic          rd_blank, rd_brk;

   assign rd_blank = (mem_rdata == BLNK_W);
   assign rd_brk   = (mem_rdata == BRK_W);

   assign alloc_en  = (state_q == ST_WRITE) && (op_q == OP_INSERT) && !rd_blank;
   assign resave_en = (state_q == ST_WRITE) && (op_q == OP_ARM_ALL) && !rd_brk;
   assign drop_en   = (state_q == ST_WRITE) && (op_q == OP_REMOVE);

   bp_slot_table #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .IW(IW)) table_i (
      .clk        (clk),
      .rst        (rst),
      .look_addr  (cmd_addr),
      .sel_idx    (cur_idx),
      .alloc_en   (alloc_en),
      .alloc_addr (cur_addr),
      .alloc_word (mem_rdata),
      .resave_en  (resave_en),
      .resave_word(mem_rdata),
      .drop_en    (drop_en),
      .hit        (tb_hit),
      .hit_idx    (tb_hit_idx),
      .has_free   (tb_has_free),
      .free_idx   (tb_free_idx),
      .sel_valid  (tb_sel_valid),
      .sel_addr   (tb_sel_addr),
      .sel_word   (tb_sel_word)
   );

   bp_break_detect #(.DW(DW), .BRK(BRK), .REG_OUT(HIT_REG)) detect_i (
      .clk         (clk),
      .rst         (rst),
      .fetch_valid (fetch_valid),
      .fetch_opcode(fetch_opcode),
      .bp_hit      (bp_hit)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= ST_IDLE;
         op_q     <= OP_INSERT;
         cur_idx  <= '0;
         cur_addr <= '0;
         err_q    <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (cmd_valid) begin
               op_q     <= bp_op_e'(cmd_op);
               cur_addr <= cmd_addr;
               err_q    <= 1'b0;
               unique case (bp_op_e'(cmd_op))
                  OP_INSERT: begin
                     if (tb_hit || !tb_has_free) begin
                        err_q   <= 1'b1;
                        state_q <= ST_DONE;
                     end else begin
                        cur_idx <= tb_free_idx;
                        state_q <= ST_READ;
                     end
                  end
                  OP_REMOVE: begin
                     if (tb_hit) begin
                        cur_idx <= tb_hit_idx;
                        state_q <= ST_WRITE;
                     end else begin
                        state_q <= ST_DONE;
                     end
                  end
                  default: begin
                     cur_idx <= '0;
                     state_q <= ST_SCAN;
                  end
               endcase
            end
            ST_READ: state_q <= ST_WRITE;
            ST_WRITE: begin
               if (op_q == OP_ARM_ALL) begin
                  if (cur_idx == LAST) state_q <= ST_DONE;
                  else begin
                     cur_idx <= cur_idx + IW'(1);
                     state_q <= ST_SCAN;
                  end
               end else begin
                  if (op_q == OP_INSERT && rd_blank) err_q <= 1'b1;
                  state_q <= ST_DONE;
               end
            end
            ST_SCAN: begin
               if (tb_sel_valid && op_q == OP_ARM_ALL) state_q <= ST_WRITE;
               else if (cur_idx == LAST)               state_q <= ST_DONE;
               else                                    cur_idx <= cur_idx + IW'(1);
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cur_addr;
      mem_wdata = BRK_W;
      unique case (state_q)
         ST_READ: mem_en = 1'b1;
         ST_WRITE: begin
            if (op_q == OP_INSERT) begin
               mem_en = !rd_blank;
               mem_we = !rd_blank;
            end else if (op_q == OP_REMOVE) begin
               mem_en    = 1'b1;
               mem_we    = 1'b1;
               mem_addr  = tb_sel_addr;
               mem_wdata = tb_sel_word;
            end else begin
               mem_en   = !rd_brk;
               mem_we   = !rd_brk;
               mem_addr = tb_sel_addr;
            end
         end
         ST_SCAN: begin
            mem_en   = tb_sel_valid;
            mem_we   = tb_sel_valid && (op_q == OP_DISARM);
            mem_addr = tb_sel_addr;
            if (op_q == OP_DISARM) mem_wdata = tb_sel_word;
         end
         default: ;
      endcase
   end

   assign busy = (state_q != ST_IDLE);
   assign done = (state_q == ST_DONE);
   assign err  = done && err_q;

endmodule

// File: rtl/bp_patch_unit_chk.sv
module bp_patch_unit_chk (
   input logic clk,
   input logic rst,
   input logic busy,
   input logic done,
   input logic err,
   input logic mem_en,
   input logic mem_we
);

   assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!busy && !mem_en));

   assert_write_needs_busy_R2: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> (busy && mem_en));

   assert_err_with_done_R4: assert property (@(posedge clk) disable iff (rst)
      err |-> done);

   assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (rst)
      done |-> busy);

   assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
      done |=> (!done && !busy));

   assert_busy_ends_on_done_R9: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> $past(done));

endmodule

bind bp_patch_unit bp_patch_unit_chk chk_i (
   .clk   (clk),
   .rst   (rst),
   .busy  (busy),
   .done  (done),
   .err   (err),
   .mem_en(mem_en),
   .mem_we(mem_we)
);

// File: tb/bp_patch_unit_tb_top.sv
module bp_patch_unit_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW    = 8;
   localparam int DW    = 16;
   localparam int DEPTH = 8;
   localparam int MSZ   = 1 << AW;
   localparam logic [15:0] BRK   = 16'h9598;
   localparam logic [15:0] BLANK = 16'hFFFF;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cmd_valid = 1'b0;
   logic [1:0]    cmd_op = 2'd0;
   logic [AW-1:0] cmd_addr = '0;
   logic          busy, done, err, mem_en, mem_we, bp_hit;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic [DW-1:0] mem_rdata = '0;
   logic          fetch_valid = 1'b0;
   logic [AW-1:0] fetch_pc = '0;
   logic [DW-1:0] fetch_opcode;

   logic [DW-1:0] mem     [MSZ];
   logic [DW-1:0] exp_mem [MSZ];
   bit            m_valid [DEPTH];
   logic [AW-1:0] m_addr  [DEPTH];
   logic [DW-1:0] m_saved [DEPTH];

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) mem[mem_addr] <= mem_wdata;
         else        mem_rdata     <= mem[mem_addr];
      end
   end

   assign fetch_opcode = mem[fetch_pc];

   bp_patch_unit #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .busy(busy), .done(done), .err(err),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .fetch_valid(fetch_valid), .fetch_opcode(fetch_opcode), .bp_hit(bp_hit)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic poke_word(input int a, input logic [15:0] w);
      mem[a]     = w;
      exp_mem[a] = w;
   endtask

   task automatic model(input int op, input int a, output bit e_err, output int e_cyc);
      int found, free, n;
      found = -1; free = -1; n = 0;
      e_err = 1'b0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (m_valid[i] && m_addr[i] == AW'(a)) found = i;
         if (!m_valid[i]) free = i;
         if (m_valid[i]) n++;
      end
      case (op)
         0: begin
            if (found >= 0 || free < 0) begin e_err = 1'b1; e_cyc = 1; end
            else if (exp_mem[a] == BLANK) begin e_err = 1'b1; e_cyc = 3; end
            else begin
               m_valid[free] = 1'b1; m_addr[free] = AW'(a);
               m_saved[free] = exp_mem[a]; exp_mem[a] = BRK; e_cyc = 3;
            end
         end
         1: begin
            if (found >= 0) begin
               exp_mem[m_addr[found]] = m_saved[found];
               m_valid[found] = 1'b0; e_cyc = 2;
            end else e_cyc = 1;
         end
         2: begin
            for (int i = 0; i < DEPTH; i++)
               if (m_valid[i] && exp_mem[m_addr[i]] != BRK) begin
                  m_saved[i] = exp_mem[m_addr[i]];
                  exp_mem[m_addr[i]] = BRK;
               end
            e_cyc = DEPTH + n + 1;
         end
         default: begin
            for (int i = 0; i < DEPTH; i++)
               if (m_valid[i]) exp_mem[m_addr[i]] = m_saved[i];
            e_cyc = DEPTH + 1;
         end
      endcase
   endtask

   task automatic check_mem(input string tag);
      int mism = 0;
      for (int i = 0; i < MSZ; i++) if (mem[i] !== exp_mem[i]) mism++;
      check(mism == 0, tag, mism, 0);
   endtask

   // poke: hold a remove of poke_a during the whole busy window
   task automatic do_cmd(input int op, input int a, input string tag,
                         input bit poke, input int poke_a);
      bit e_err; int e_cyc; int cyc; int dones; int errs;
      model(op, a, e_err, e_cyc);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'(op); cmd_addr = AW'(a);
      @(negedge clk);
      cmd_valid = 1'b0;
      cyc = 0; dones = 0; errs = 0;
      while (busy && cyc < 200) begin
         if (done) dones++;
         if (err)  errs++;
         cyc++;
         cmd_valid = poke && !done;
         cmd_op    = 2'd1;
         cmd_addr  = AW'(poke_a);
         @(negedge clk);
      end
      cmd_valid = 1'b0;
      check(cyc == e_cyc, {tag, " busy cycles"}, cyc, e_cyc);
      check(dones == 1, {tag, " R9 single done"}, dones, 1);
      check(errs == int'(e_err), {tag, " err"}, errs, int'(e_err));
      check_mem({tag, " memory image"});
   endtask

   initial begin
      for (int i = 0; i < MSZ; i++) poke_word(i, 16'(i * 16'h0123 + 16'h0042));
      for (int i = 0; i < DEPTH; i++) m_valid[i] = 1'b0;
      poke_word(8'h30, BLANK);
      poke_word(8'h40, BRK);
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      check(!busy && !done && !err && !mem_en, "R1 idle after reset", {busy, done, err, mem_en}, 0);
      do_cmd(2, 0, "R1 enable-all on empty table", 1'b0, 0);
      do_cmd(1, 8'h21, "R6 remove miss", 1'b0, 0);

      // R2 + R10: insert while fetch watches the same address
      fetch_valid = 1'b1; fetch_pc = 8'h20;
      begin
         bit e_err; int e_cyc;
         model(0, 8'h20, e_err, e_cyc);
         @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = 8'h20;
         @(negedge clk); cmd_valid = 1'b0;
         check(busy && !bp_hit, "R10 no hit in read cycle", bp_hit, 0);
         @(negedge clk);
         check(busy && !bp_hit && !done, "R10 no hit in write cycle", bp_hit, 0);
         @(negedge clk);
         check(done && bp_hit, "R10 hit in done cycle", {done, bp_hit}, 3);
         @(negedge clk);
         check(!busy, "R2 idle after 3 busy cycles", busy, 0);
         check(mem[8'h20] == BRK, "R2 break opcode written", mem[8'h20], BRK);
         check_mem("R2 memory image");
      end
      fetch_valid = 1'b0;
      @(negedge clk);
      check(!bp_hit, "R10 no hit without fetch_valid", bp_hit, 0);
      fetch_valid = 1'b1; fetch_pc = 8'h21;
      @(negedge clk);
      check(!bp_hit, "R10 no hit on ordinary word", bp_hit, 0);

      do_cmd(0, 8'h30, "R3 insert on erased word", 1'b0, 0);
      do_cmd(0, 8'h40, "R2 insert on word already break", 1'b0, 0);
      for (int k = 0; k < 6; k++) do_cmd(0, 8'h50 + 5 * k, "R2 fill table", 1'b0, 0);
      do_cmd(0, 8'h90, "R4 insert into full table", 1'b0, 0);
      do_cmd(1, 8'h50, "R5 remove present entry", 1'b0, 0);
      do_cmd(0, 8'h20, "R4 duplicate insert", 1'b0, 0);
      do_cmd(0, 8'h50, "R5 freed entry reused", 1'b0, 0);

      // R7 with a remove held during the walk: R9 says it is ignored
      do_cmd(3, 0, "R7 disable-all, R9 busy command ignored", 1'b1, 8'h20);
      poke_word(8'h55, 16'h1357);
      do_cmd(2, 0, "R8 enable-all re-patch", 1'b0, 0);
      check(mem[8'h20] == BRK, "R9 ignored remove left entry armed", mem[8'h20], BRK);
      fetch_pc = 8'h55;
      @(negedge clk);
      check(bp_hit, "R10 hit on re-patched word", bp_hit, 1);
      do_cmd(2, 0, "R8 enable-all when all armed", 1'b0, 0);
      do_cmd(1, 8'h55, "R8 new original restored by remove", 1'b0, 0);
      check(mem[8'h55] == 16'h1357, "R8 resaved word", mem[8'h55], 16'h1357);
      do_cmd(1, 8'h40, "R5 remove entry saved as break", 1'b0, 0);
      do_cmd(3, 0, "R7 disable-all again", 1'b0, 0);
      do_cmd(2, 0, "R8 enable-all again", 1'b0, 0);

      // R1: reset with entries present leaves memory and empties table
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      for (int i = 0; i < DEPTH; i++) m_valid[i] = 1'b0;
      check_mem("R1 reset leaves memory");
      do_cmd(3, 0, "R1 disable-all after reset", 1'b0, 0);
      do_cmd(1, 8'h20, "R1 remove after reset misses", 1'b0, 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule